// File: doc/BRIEF.md
# Natural Loopback Receive Path Selector

This block decides, nibble by nibble, what a 10BASE-T PHY presents on the receive data bus of its media independent interface. It has two sources. The first is the line receiver, which supplies decoded receive nibbles and their valid strobe. The second is the PHY's own transmit path, which supplies the transmit nibbles and transmit enable. Manchester decoding happens upstream and is not part of this block.

When the natural loopback control bit is set, the link runs 10 Mb/s half duplex, and the PHY is transmitting while the line shows no receive activity, the transmit nibbles are returned on the receive bus. The data-valid strobe then follows transmit enable. A collision always overrides loopback, and line data is routed instead. In every other situation the block passes line data and line valid straight through. This covers full duplex, 100 Mb/s, loopback disabled and not transmitting.

Data and valid are chosen together from one source and registered in the same stage. A change of source therefore lands on a clock edge, which is a nibble boundary. A receive nibble never mixes the two sources.

Top module: `nlb_rx_select`

## Requirements
- R1: While `rst_n` is low, `rxd` reads 0 and `rx_dv` reads 0.
- R2: Loopback is selected when all of these hold: `cfg_loop_en`=1, `mode_10m`=1, `full_duplex`=0, `tx_en`=1, `line_crs`=0 and `line_col`=0. In that case the next clock edge gives `rxd` = `txd` and `rx_dv` = 1.
- R3: When `line_col`=1, the next edge gives `rxd` = `line_rxd` and `rx_dv` = `line_rx_dv`, even if all other loopback conditions hold.
- R4: When `line_crs`=1 and the PHY is transmitting, the next edge gives line data and line valid.
- R5: When `cfg_loop_en`=0, `txd` and `tx_en` have no effect on the outputs, and the next edge gives line data and line valid.
- R6: When `full_duplex`=1, the block passes line data and line valid through, even if the other loopback conditions hold.
- R7: When `mode_10m`=0 (100 Mb/s), the block passes line data and line valid through, even if the other loopback conditions hold.
- R8: When `tx_en`=0, the next edge gives `rxd` = `line_rxd` and `rx_dv` = `line_rx_dv`.
- R9: Both outputs are registered with exactly one cycle of latency. On every edge, `rxd` and `rx_dv` come from the same source, including on consecutive cycles that switch between loopback and line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_loop_en | input | 1 | Natural loopback enable bit |
| mode_10m | input | 1 | 1 = 10 Mb/s operation, 0 = 100 Mb/s |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_en | input | 1 | Transmit enable from the MAC |
| txd | input | DATA_W | Transmit data nibble |
| line_rxd | input | DATA_W | Receive nibble from the line receiver |
| line_rx_dv | input | 1 | Valid strobe from the line receiver |
| line_crs | input | 1 | Receive activity detected on the line |
| line_col | input | 1 | Collision flag |
| rxd | output | DATA_W | Receive data nibble toward the MAC |
| rx_dv | output | 1 | Receive data-valid toward the MAC |

## Verification
The bench builds the block with its default `DATA_W` of 4, which matches the nibble width of the interface. Transmit and line nibbles always carry different values, and line valid is held opposite to transmit enable wherever that helps. This makes the source of every output cycle identifiable from `rxd` and `rx_dv` alone. It also exposes a mixed-source nibble during back-to-back switches between loopback and collision.

// File: rtl/nlb_pkg.sv
package nlb_pkg;
    typedef enum logic {
        SRC_LINE = 1'b0,
        SRC_LOOP = 1'b1
    } src_e;
endpackage

// File: rtl/nlb_mode_qual.sv
module nlb_mode_qual
    import nlb_pkg::*;
(
    input  logic cfg_loop_en,
    input  logic mode_10m,
    input  logic full_duplex,
    input  logic tx_en,
    input  logic line_crs,
    input  logic line_col,
    output src_e src_sel
);
    logic mode_ok;
    logic tx_alone;

    always_comb begin
        // loopback only exists in 10 Mb/s half duplex
        mode_ok  = cfg_loop_en && mode_10m && !full_duplex;
        // transmitting with a quiet line; collision always wins
        tx_alone = tx_en && !line_crs && !line_col;
        src_sel  = (mode_ok && tx_alone) ? SRC_LOOP : SRC_LINE;
    end
endmodule

// File: rtl/nlb_out_stage.sv
module nlb_out_stage
    import nlb_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_e              src_sel,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] txd,
    input  logic [DATA_W-1:0] line_rxd,
    input  logic              line_rx_dv,
    output logic [DATA_W-1:0] rxd,
    output logic              rx_dv
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              dv;
    } beat_t;

    beat_t beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        // data and valid taken as one unit from a single source
        if (src_sel == SRC_LOOP) begin
            beat_d.data = txd;
            beat_d.dv   = tx_en;
        end else begin
            beat_d.data = line_rxd;
            beat_d.dv   = line_rx_dv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_d;
    end

    assign rxd   = beat_q.data;
    assign rx_dv = beat_q.dv;

    // R9: a nibble chosen from the line carries the line's valid with it
    p_line_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_LINE) |=> (rxd == $past(line_rxd)) && (rx_dv == $past(line_rx_dv)));
endmodule

// File: rtl/nlb_rx_select.sv
module nlb_rx_select
    import nlb_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_loop_en,
    input  logic              mode_10m,
    input  logic              full_duplex,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] txd,
    input  logic [DATA_W-1:0] line_rxd,
    input  logic              line_rx_dv,
    input  logic              line_crs,
    input  logic              line_col,
    output logic [DATA_W-1:0] rxd,
    output logic              rx_dv
);
    src_e src_sel;

    nlb_mode_qual u_qual (
        .cfg_loop_en (cfg_loop_en),
        .mode_10m    (mode_10m),
        .full_duplex (full_duplex),
        .tx_en       (tx_en),
        .line_crs    (line_crs),
        .line_col    (line_col),
        .src_sel     (src_sel)
    );

    nlb_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .tx_en      (tx_en),
        .txd        (txd),
        .line_rxd   (line_rxd),
        .line_rx_dv (line_rx_dv),
        .rxd        (rxd),
        .rx_dv      (rx_dv)
    );

    // R1: an edge seen in reset leaves the outputs quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (rx_dv == 1'b0) && (rxd == '0));

    // R2: qualified transmit returns the transmit nibble with valid set
    p_loop_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_loop_en && mode_10m && !full_duplex && tx_en && !line_crs && !line_col)
        |=> (rxd == $past(txd)) && rx_dv);

    // R3: collision routes line data
    p_col_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_col |=> (rxd == $past(line_rxd)) && (rx_dv == $past(line_rx_dv)));

    // R5: loopback disabled means pass-through
    p_off_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_loop_en |=> (rxd == $past(line_rxd)) && (rx_dv == $past(line_rx_dv)));

    // R6: full duplex means pass-through
    p_fdx_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |=> (rxd == $past(line_rxd)) && (rx_dv == $past(line_rx_dv)));

    // R7: 100 Mb/s means pass-through
    p_fast_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10m |=> (rxd == $past(line_rxd)) && (rx_dv == $past(line_rx_dv)));
endmodule

// File: tb/test_nlb_rx_select.sv
module test_nlb_rx_select;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_loop_en = 1'b0, mode_10m = 1'b1, full_duplex = 1'b0;
    logic         tx_en = 1'b0, line_rx_dv = 1'b0, line_crs = 1'b0, line_col = 1'b0;
    logic [W-1:0] txd = '0, line_rxd = '0;
    logic [W-1:0] rxd;
    logic         rx_dv;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    nlb_rx_select #(.DATA_W(W)) i_nlb_rx_select (
        .clk(clk), .rst_n(rst_n), .cfg_loop_en(cfg_loop_en), .mode_10m(mode_10m),
        .full_duplex(full_duplex), .tx_en(tx_en), .txd(txd), .line_rxd(line_rxd),
        .line_rx_dv(line_rx_dv), .line_crs(line_crs), .line_col(line_col),
        .rxd(rxd), .rx_dv(rx_dv)
    );

    task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {dv,rxd} actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one nibble at the falling edge, then look just after the next rising edge
    task automatic step(input logic en, input logic m10, input logic fdx, input logic te,
                        input logic [W-1:0] td, input logic [W-1:0] lrd, input logic ldv,
                        input logic crs, input logic col);
        @(negedge clk);
        cfg_loop_en = en; mode_10m = m10; full_duplex = fdx; tx_en = te;
        txd = td; line_rxd = lrd; line_rx_dv = ldv; line_crs = crs; line_col = col;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        step(1, 1, 0, 1, 4'hF, 4'hE, 1, 0, 0);
        chk("R1", {rx_dv, rxd}, 5'h00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_loop;
        for (int v = 1; v < 16; v += 3) begin
            step(1, 1, 0, 1, 4'(v), 4'(~v), 0, 0, 0);
            chk("R2", {rx_dv, rxd}, {1'b1, 4'(v)});
        end
    endtask

    task automatic t_collision;
        step(1, 1, 0, 1, 4'h3, 4'hC, 0, 1, 1);
        chk("R3", {rx_dv, rxd}, {1'b0, 4'hC});
        step(1, 1, 0, 1, 4'h3, 4'h9, 1, 0, 1);
        chk("R3", {rx_dv, rxd}, {1'b1, 4'h9});
    endtask

    task automatic t_receiving;
        step(1, 1, 0, 1, 4'h6, 4'h1, 0, 1, 0);
        chk("R4", {rx_dv, rxd}, {1'b0, 4'h1});
        step(1, 1, 0, 1, 4'h6, 4'h2, 1, 1, 0);
        chk("R4", {rx_dv, rxd}, {1'b1, 4'h2});
    endtask

    task automatic t_disabled;
        step(0, 1, 0, 1, 4'hA, 4'h5, 0, 0, 0);
        chk("R5", {rx_dv, rxd}, {1'b0, 4'h5});
        step(0, 1, 0, 1, 4'h7, 4'h5, 0, 0, 0);
        chk("R5", {rx_dv, rxd}, {1'b0, 4'h5});
    endtask

    task automatic t_full_duplex;
        step(1, 1, 1, 1, 4'hA, 4'h4, 0, 0, 0);
        chk("R6", {rx_dv, rxd}, {1'b0, 4'h4});
    endtask

    task automatic t_fast;
        step(1, 0, 0, 1, 4'hA, 4'hB, 0, 0, 0);
        chk("R7", {rx_dv, rxd}, {1'b0, 4'hB});
        step(1, 0, 1, 1, 4'hA, 4'h8, 1, 0, 0);
        chk("R7", {rx_dv, rxd}, {1'b1, 4'h8});
    endtask

    task automatic t_idle;
        step(1, 1, 0, 0, 4'hA, 4'hD, 1, 1, 0);
        chk("R8", {rx_dv, rxd}, {1'b1, 4'hD});
        step(1, 1, 0, 0, 4'hA, 4'h0, 0, 0, 0);
        chk("R8", {rx_dv, rxd}, {1'b0, 4'h0});
    endtask

    task automatic t_switch;
        step(1, 1, 0, 1, 4'h1, 4'hE, 0, 0, 0);
        chk("R9", {rx_dv, rxd}, {1'b1, 4'h1});
        step(1, 1, 0, 1, 4'h2, 4'hD, 0, 1, 1);
        chk("R9", {rx_dv, rxd}, {1'b0, 4'hD});
        step(1, 1, 0, 1, 4'h3, 4'hC, 0, 0, 0);
        chk("R9", {rx_dv, rxd}, {1'b1, 4'h3});
        // latency: one more edge with inputs changed only after sampling
        @(negedge clk);
        txd = 4'h9;
        #1;
        chk("R9", {rx_dv, rxd}, {1'b1, 4'h3});
        @(posedge clk);
        #1;
        chk("R9", {rx_dv, rxd}, {1'b1, 4'h9});
    endtask

    initial begin
        t_reset();
        t_loop();
        t_collision();
        t_receiving();
        t_disabled();
        t_full_duplex();
        t_fast();
        t_idle();
        t_switch();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule